// File: doc/BRIEF.md
# Shared-Memory Mailbox Register Block

This block is the 32-bit register file that sits in front of an inter-VM shared-memory device. A host on a simple valid/write/address/size bus programs an interrupt enable mask, reads and clears an interrupt cause register, reads the local node identity, and rings remote nodes through a doorbell register. The block drives one level-sensitive interrupt line. It issues a one-cycle doorbell request that carries a destination node number and a vector number. Routing that request to a peer is done outside the block.

Inbound notifications arrive on a separate event port and overwrite the cause register with their byte payload. Reading the cause register clears it in the same access. If a read and an inbound event land in the same cycle, the clear is done first and the event is kept for one cycle, so it is never dropped. Only full-word accesses reach the registers. Narrower writes do nothing, and narrower reads return zero.

Top module: `shm_mailbox_regs`

## Requirements
- R1: The register map is: enable mask at offset 0x00, cause at 0x04, identity at 0x08 and doorbell at 0x0C. The size code is 0 for a byte, 1 for a half word and 2 for a word, and 3 counts as not a word. A word read of the doorbell offset or of any other offset returns zero.
- R2: `irq` is high exactly when the bitwise AND of cause and mask is non-zero. It updates on the same clock edge as the register change that causes it.
- R3: A word read of the cause register returns its current value, and the register is zero afterwards.
- R4: Word writes to mask or cause load all 32 bits as written. There is no write-one-to-clear behaviour.
- R5: A word write to the doorbell raises `db_fire` for exactly one cycle, starting on the next cycle. `db_dest` carries write bits 31:16 and `db_vector` carries write bits 7:0. Bits 15:8 have no effect.
- R6: A word read of the identity offset returns `node_id` when `shm_ready` is high, and 0xFFFFFFFF otherwise.
- R7: Byte and half-word writes change no register and raise no doorbell. Byte and half-word reads return zero and do not clear the cause register.
- R8: An inbound event loads the cause register with its 8-bit payload, zero-extended to 32 bits.
- R9: Synchronous reset clears the cause and mask registers and drives `irq`, `db_fire` and `rd_valid` low.
- R10: For writes, the address is ANDed with 0xFC before decoding, so a word write to 0x07 reaches the cause register. Reads decode the exact address, so a word read of 0x05 returns zero.
- R11: If a cause read and an inbound event happen in the same cycle, the read returns the value from before the clear and the cause register becomes zero. The event payload is loaded one cycle later.
- R12: Read data and `rd_valid` are registered. They appear on the cycle after the request, and `rd_valid` is high for every read request, whatever its size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the 256-byte window |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| evt_valid | input | 1 | Inbound event notification |
| evt_payload | input | 8 | Event byte loaded into the cause register |
| shm_ready | input | 1 | Shared memory attached |
| node_id | input | 32 | Local node identity |
| irq | output | 1 | Level interrupt |
| db_fire | output | 1 | One-cycle doorbell request |
| db_dest | output | 16 | Doorbell destination node |
| db_vector | output | 8 | Doorbell vector |

## Verification
The bench targets the corner cases that are easy to get wrong in this block:
- **Read-clear collision.** A cause read collides with an inbound event. A design that let the event win would return the new value or leave the cause set. A design that dropped the event would never raise `irq` on the following cycle.
- **Narrow accesses.** Byte and half-word writes are sent to mask, cause and doorbell. A design that decoded them would change the interrupt level or fire a doorbell. A half-word read of cause is also sent, and a design that decoded it would lose the pending cause.
- **Asymmetric address decode.** A write to 0x07 must reach the cause register, while a read of 0x05 must return zero.
- **Doorbell packing and identity fallback.** The doorbell write data has bits 15:8 set, to catch a design that packs the vector from the wrong byte. The identity register is read with the memory detached, to catch a missing all-ones fallback.

// File: rtl/shm_regs_pkg.sv
package shm_regs_pkg;

    parameter int DATA_W = 32;
    parameter int ADDR_W = 8;
    parameter int DEST_W = 16;
    parameter int VEC_W  = 8;
    parameter int EVT_W  = 8;

    // Bit positions the peer-routing logic decodes from a doorbell word
    localparam int DEST_LSB = 16;
    localparam int VEC_LSB  = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IDENT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_BELL  = 8'h0C;
    localparam logic [ADDR_W-1:0] WR_ALIGN  = 8'hFC;

    typedef struct packed {
        logic mask_wr;
        logic cause_wr;
        logic cause_rd;
        logic mask_rd;
        logic ident_rd;
        logic bell_wr;
    } reg_sel_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [VEC_W-1:0]  vector;
    } bell_req_t;

    function automatic logic is_word(input logic [1:0] sz);
        return acc_size_e'(sz) == SZ_WORD;
    endfunction

endpackage

// File: rtl/shm_bus_decode.sv
module shm_bus_decode
    import shm_regs_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output reg_sel_t      sel
);
    logic          word_acc;
    logic [AW-1:0] wr_addr;

    always_comb begin
        word_acc = valid && is_word(size);
        wr_addr  = addr & WR_ALIGN;
        sel.mask_wr  = word_acc &&  write && (wr_addr == OFF_MASK);
        sel.cause_wr = word_acc &&  write && (wr_addr == OFF_CAUSE);
        sel.bell_wr  = word_acc &&  write && (wr_addr == OFF_BELL);
        sel.mask_rd  = word_acc && !write && (addr == OFF_MASK);
        sel.cause_rd = word_acc && !write && (addr == OFF_CAUSE);
        sel.ident_rd = word_acc && !write && (addr == OFF_IDENT);
    end
endmodule

// File: rtl/shm_irq_core.sv
module shm_irq_core
    import shm_regs_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int EW = EVT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mask_wr,
    input  logic          cause_wr,
    input  logic          cause_rd,
    input  logic [DW-1:0] wdata,
    input  logic          evt_valid,
    input  logic [EW-1:0] evt_payload,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] cause_q,
    output logic          irq
);
    logic          pend_q;
    logic [EW-1:0] pend_data_q;
    logic          evt_any;
    logic [EW-1:0] evt_sel;
    logic          cause_busy;
    logic [DW-1:0] mask_d, cause_d;

    always_comb begin
        evt_any    = evt_valid || pend_q;
        evt_sel    = evt_valid ? evt_payload : pend_data_q;
        cause_busy = cause_rd || cause_wr;
        mask_d     = mask_wr ? wdata : mask_q;
        if (cause_rd)
            cause_d = '0;
        else if (cause_wr)
            cause_d = wdata;
        else if (evt_any)
            cause_d = {{(DW-EW){1'b0}}, evt_sel};
        else
            cause_d = cause_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q      <= '0;
            cause_q     <= '0;
            irq         <= 1'b0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else begin
            mask_q  <= mask_d;
            cause_q <= cause_d;
            irq     <= |(cause_d & mask_d);
            if (evt_any && cause_busy) begin
                pend_q      <= 1'b1;
                pend_data_q <= evt_sel;
            end else begin
                pend_q      <= 1'b0;
            end
        end
    end

    // R2
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq == |(cause_q & mask_q));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cause_rd |=> cause_q == '0);

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));

    // R11
    collision_defer_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_rd && evt_valid) |=> pend_q);
endmodule

// File: rtl/shm_bell_gen.sv
module shm_bell_gen
    import shm_regs_pkg::*;
#(
    parameter int DSW = DEST_W,
    parameter int VW  = VEC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  logic [DSW-1:0] dest_in,
    input  logic [VW-1:0]  vec_in,
    output logic           strobe,
    output bell_req_t      req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
            req    <= '0;
        end else begin
            strobe <= fire;
            if (fire) begin
                req.dest   <= dest_in;
                req.vector <= vec_in;
            end
        end
    end

    // R5
    bell_cause_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(fire));

    // R5
    bell_follow_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> strobe);
endmodule

// File: rtl/shm_read_port.sv
module shm_read_port
    import shm_regs_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          mask_rd,
    input  logic          cause_rd,
    input  logic          ident_rd,
    input  logic [DW-1:0] mask_q,
    input  logic [DW-1:0] cause_q,
    input  logic          shm_ready,
    input  logic [DW-1:0] node_id,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (mask_rd)  rd_mux = mask_q;
        if (cause_rd) rd_mux = cause_q;
        if (ident_rd) rd_mux = shm_ready ? node_id : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? rd_mux : '0;
        end
    end

    // R12
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mask_rd, cause_rd, ident_rd}));
endmodule

// File: rtl/shm_mailbox_regs.sv
module shm_mailbox_regs
    import shm_regs_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int DSW = DEST_W,
    parameter int VW  = VEC_W,
    parameter int EW  = EVT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_valid,
    input  logic           bus_write,
    input  logic [AW-1:0]  bus_addr,
    input  logic [1:0]     bus_size,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid,
    input  logic           evt_valid,
    input  logic [EW-1:0]  evt_payload,
    input  logic           shm_ready,
    input  logic [DW-1:0]  node_id,
    output logic           irq,
    output logic           db_fire,
    output logic [DSW-1:0] db_dest,
    output logic [VW-1:0]  db_vector
);
    reg_sel_t      sel;
    logic [DW-1:0] mask_q, cause_q;
    bell_req_t     bell;
    logic          rd_req;

    assign rd_req = bus_valid && !bus_write;

    shm_bus_decode #(.AW(AW)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .size  (bus_size),
        .sel   (sel)
    );

    shm_irq_core #(.DW(DW), .EW(EW)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .mask_wr     (sel.mask_wr),
        .cause_wr    (sel.cause_wr),
        .cause_rd    (sel.cause_rd),
        .wdata       (bus_wdata),
        .evt_valid   (evt_valid),
        .evt_payload (evt_payload),
        .mask_q      (mask_q),
        .cause_q     (cause_q),
        .irq         (irq)
    );

    shm_bell_gen #(.DSW(DSW), .VW(VW)) u_bell (
        .clk     (clk),
        .rst     (rst),
        .fire    (sel.bell_wr),
        .dest_in (bus_wdata[DEST_LSB +: DSW]),
        .vec_in  (bus_wdata[VEC_LSB +: VW]),
        .strobe  (db_fire),
        .req     (bell)
    );

    shm_read_port #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .mask_rd   (sel.mask_rd),
        .cause_rd  (sel.cause_rd),
        .ident_rd  (sel.ident_rd),
        .mask_q    (mask_q),
        .cause_q   (cause_q),
        .shm_ready (shm_ready),
        .node_id   (node_id),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign db_dest   = bell.dest;
    assign db_vector = bell.vector;
endmodule

// File: tb/shm_mailbox_regs_test.sv
module shm_mailbox_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_payload = '0;
    logic        shm_ready = 1'b1;
    logic [31:0] node_id = 32'h0000_0005;
    logic        irq;
    logic        db_fire;
    logic [15:0] db_dest;
    logic [7:0]  db_vector;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    shm_mailbox_regs uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .evt_valid(evt_valid),
        .evt_payload(evt_payload), .shm_ready(shm_ready), .node_id(node_id),
        .irq(irq), .db_fire(db_fire), .db_dest(db_dest), .db_vector(db_vector)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t TABLE [NVEC] = '{
        '{1'b1, 8'h00, 2'd2, 32'h0000_00F0, 32'h0, 1'b0, 4'd4},  // R4 mask
        '{1'b1, 8'h04, 2'd2, 32'h0000_0010, 32'h0, 1'b1, 4'd2},  // R2 irq rises
        '{1'b0, 8'h00, 2'd2, 32'h0, 32'h0000_00F0, 1'b1, 4'd1},  // R1 mask readback
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0010, 1'b0, 4'd3},  // R3 read clears
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0000, 1'b0, 4'd3},  // R3 now zero
        '{1'b1, 8'h04, 2'd0, 32'h0000_00FF, 32'h0, 1'b0, 4'd7},  // R7 byte write
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0000, 1'b0, 4'd7},  // R7 unchanged
        '{1'b1, 8'h00, 2'd1, 32'h0000_0000, 32'h0, 1'b0, 4'd7},  // R7 half write
        '{1'b0, 8'h00, 2'd2, 32'h0, 32'h0000_00F0, 1'b0, 4'd7},  // R7 mask kept
        '{1'b0, 8'h08, 2'd2, 32'h0, 32'h0000_0005, 1'b0, 4'd6},  // R6 identity
        '{1'b0, 8'h0C, 2'd2, 32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1 doorbell reads 0
        '{1'b0, 8'h40, 2'd2, 32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1 unmapped
        '{1'b1, 8'h07, 2'd2, 32'h0000_0020, 32'h0, 1'b1, 4'd10}, // R10 masked write
        '{1'b0, 8'h05, 2'd2, 32'h0, 32'h0000_0000, 1'b1, 4'd10}, // R10 exact read
        '{1'b0, 8'h04, 2'd1, 32'h0, 32'h0000_0000, 1'b1, 4'd7},  // R7 half read
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0020, 1'b0, 4'd3},  // R3
        '{1'b1, 8'h04, 2'd2, 32'hFFFF_0001, 32'h0, 1'b0, 4'd4},  // R4 full load
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'hFFFF_0001, 1'b0, 4'd4}   // R4
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle access; returns at the falling edge after the sampling edge
    task automatic bus_op(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(9, {31'b0, irq}, 32'h0);
        chk(9, {31'b0, db_fire}, 32'h0);
        chk(9, {31'b0, rd_valid}, 32'h0);
        rst = 1'b0;

        // Table walk
        foreach (TABLE[i]) begin
            bus_op(TABLE[i].wr, TABLE[i].addr, TABLE[i].size, TABLE[i].data);
            if (!TABLE[i].wr) begin
                chk(12, {31'b0, rd_valid}, 32'h1);           // R12
                chk(int'(TABLE[i].req), rd_data, TABLE[i].exp_rd);
            end
            chk(int'(TABLE[i].req), {31'b0, irq}, {31'b0, TABLE[i].exp_irq});
        end
        @(negedge clk);
        chk(12, {31'b0, rd_valid}, 32'h0);                    // R12 one cycle only

        // R5 doorbell packing; bits 15:8 set to 0x5A must not leak
        bus_op(1'b1, 8'h0C, 2'd2, 32'hABCD_5A37);
        chk(5, {31'b0, db_fire}, 32'h1);
        chk(5, {16'b0, db_dest}, 32'h0000_ABCD);
        chk(5, {24'b0, db_vector}, 32'h0000_0037);
        @(negedge clk);
        chk(5, {31'b0, db_fire}, 32'h0);
        // R7 byte doorbell write fires nothing
        bus_op(1'b1, 8'h0C, 2'd0, 32'h1111_2222);
        chk(7, {31'b0, db_fire}, 32'h0);
        // R10 word write at 0x0E aligns to doorbell
        bus_op(1'b1, 8'h0E, 2'd2, 32'h0007_0003);
        chk(10, {31'b0, db_fire}, 32'h1);
        chk(10, {16'b0, db_dest}, 32'h0000_0007);

        // R6 identity when detached
        shm_ready = 1'b0;
        bus_op(1'b0, 8'h08, 2'd2, 32'h0);
        chk(6, rd_data, 32'hFFFF_FFFF);
        shm_ready = 1'b1;

        // R8 inbound event loads zero-extended byte
        bus_op(1'b1, 8'h00, 2'd2, 32'h0000_0080);
        @(negedge clk);
        evt_valid = 1'b1; evt_payload = 8'hC3;
        @(negedge clk);
        evt_valid = 1'b0;
        chk(8, {31'b0, irq}, 32'h1);
        bus_op(1'b0, 8'h04, 2'd2, 32'h0);
        chk(8, rd_data, 32'h0000_00C3);

        // R11 read/event collision
        bus_op(1'b1, 8'h00, 2'd2, 32'h0000_0001);
        bus_op(1'b1, 8'h04, 2'd2, 32'h0000_0011);
        chk(11, {31'b0, irq}, 32'h1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h04; bus_size = 2'd2;
        evt_valid = 1'b1; evt_payload = 8'h01;
        @(negedge clk);
        bus_valid = 1'b0; evt_valid = 1'b0;
        chk(11, rd_data, 32'h0000_0011);
        chk(11, {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk(11, {31'b0, irq}, 32'h1);
        bus_op(1'b0, 8'h04, 2'd2, 32'h0);
        chk(11, rd_data, 32'h0000_0001);

        // R9 mid-run reset clears mask and cause
        bus_op(1'b1, 8'h04, 2'd2, 32'h0000_0001);
        chk(9, {31'b0, irq}, 32'h1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(9, {31'b0, irq}, 32'h0);
        bus_op(1'b0, 8'h00, 2'd2, 32'h0);
        chk(9, rd_data, 32'h0);
        bus_op(1'b0, 8'h04, 2'd2, 32'h0);
        chk(9, rd_data, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule